// File: doc/BRIEF.md
# Write Status Polling Logic

This block forms the byte placed on the data bus of a byte-wide non-volatile memory when the host reads it. While the write sequencer reports an internal programming cycle in progress, the byte carries two in-band status bits instead of array contents. The top bit is the inverse of the top bit of the last byte loaded. The next bit flips once per read attempt. The remaining low bits are held at zero. A host therefore needs no separate ready/busy pin. It either reads until the top bit matches what it wrote, or reads until the toggle bit stops changing.

When no programming cycle is running, the block passes the array read data to the bus unchanged. Byte loads arrive as a one-cycle strobe with the data latched by the write front end. Every load overwrites the stored byte, so after a page load the final byte of the page is the one reported. Reads arrive as a level that is high for the duration of a read access.

Top module: `wr_status_poll`

## Requirements
- R1: While `busy_i` is 0, `bus_data_o` equals `array_data_i` on every bit, combinationally.
- R2: Each cycle with `wr_load_i` high stores `wr_data_i` at that clock edge. Later loads replace earlier ones, so the last byte of a page load is the one used for polling.
- R3: While `busy_i` is 1, bit W-1 of `bus_data_o` (bit 7 at the default W=8) is the complement of bit W-1 of the stored byte.
- R4: While `busy_i` is 1, bit W-2 (bit 6 at the default W=8) inverts at each clock edge where `rd_active_i` is 1 and was 0 at the previous edge. A read held high for several cycles causes only one inversion.
- R5: The toggle bit is cleared whenever `busy_i` is 0. Each programming cycle therefore shows 0 until its first read edge, and 1 after that edge.
- R6: While `busy_i` is 1, bits W-3 down to 0 of `bus_data_o` are 0.
- R7: In the cycle where `busy_i` falls, `bus_data_o` already returns the true array data (no added latency), and toggling stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Programming cycle in progress, from the write sequencer |
| rd_active_i | input | 1 | High while a host read access is active |
| wr_load_i | input | 1 | One-cycle strobe for an accepted byte load |
| wr_data_i | input | W | Latched write data of the byte load |
| array_data_i | input | W | Data read from the memory array |
| bus_data_o | output | W | Byte to drive onto the data bus |

## Verification
The output mux is combinational. The pass-through, the reserved zeros and the end-of-busy return (R1, R6, R7) are therefore due in the same cycle the inputs change. The stored byte (R2, R3) and the toggle state (R4, R5) are registers. Their effect appears in the cycle after the clock edge that captures the load or the read edge. The bench drives inputs on the falling edge and compares outputs one nanosecond later, still before the next rising edge. It updates its reference state only after that rising edge, so every comparison sees exactly the registered state the design should hold at that moment.

// File: rtl/wr_status_poll.sv
module wr_status_poll #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy_i,
  input  logic         rd_active_i,
  input  logic         wr_load_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] array_data_i,
  output logic [W-1:0] bus_data_o
);

  localparam int POLL_BIT = W - 1;
  localparam int TGL_BIT  = W - 2;
  localparam int RSV_W    = W - 2;

  logic [W-1:0] last_wr_q;
  logic         rd_q;
  logic         tgl_q;
  logic         rd_edge;

  assign rd_edge = rd_active_i & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr_q <= '0;
      rd_q      <= 1'b0;
      tgl_q     <= 1'b0;
    end else begin
      rd_q <= rd_active_i;
      if (wr_load_i) last_wr_q <= wr_data_i;
      if (!busy_i)      tgl_q <= 1'b0;
      else if (rd_edge) tgl_q <= ~tgl_q;
    end
  end

  assign bus_data_o = busy_i ? {~last_wr_q[POLL_BIT], tgl_q, {RSV_W{1'b0}}}
                             : array_data_i;

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> bus_data_o == array_data_i); // R1

  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load_i |=> (!busy_i || wr_load_i || bus_data_o[POLL_BIT] != $past(wr_data_i[POLL_BIT]))); // R3

  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_active_i && !rd_q) |=> (!busy_i || bus_data_o[TGL_BIT] != $past(bus_data_o[TGL_BIT]))); // R4

  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !(rd_active_i && !rd_q)) |=> (!busy_i || $stable(bus_data_o[TGL_BIT]))); // R4

  AST_TGL_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> bus_data_o[TGL_BIT] == 1'b0); // R5

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> bus_data_o[RSV_W-1:0] == '0); // R6

  AST_DONE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |-> bus_data_o == array_data_i); // R7

endmodule

// File: tb/tb_wr_status_poll.sv
module tb_wr_status_poll;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         busy_i = 1'b0;
  logic         rd_active_i = 1'b0;
  logic         wr_load_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] array_data_i = '0;
  logic [W-1:0] bus_data_o;

  int vectors = 0;
  int errors  = 0;

  logic [W-1:0] m_last = '0;
  logic         m_tgl  = 1'b0;
  logic         m_rdp  = 1'b0;

  always #2.5 clk = ~clk;

  wr_status_poll #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .rd_active_i(rd_active_i),
    .wr_load_i(wr_load_i), .wr_data_i(wr_data_i), .array_data_i(array_data_i),
    .bus_data_o(bus_data_o)
  );

  function automatic logic [W-1:0] expect_bus(input logic b, input logic [W-1:0] arr,
                                              input logic [W-1:0] last, input logic t);
    if (!b) return arr;
    return {~last[W-1], t, {(W-2){1'b0}}};
  endfunction

  task automatic step(input logic b, input logic rd, input logic ld,
                      input logic [W-1:0] wd, input logic [W-1:0] ad, input string req);
    logic [W-1:0] exp;
    @(negedge clk);
    busy_i = b; rd_active_i = rd; wr_load_i = ld; wr_data_i = wd; array_data_i = ad;
    #1;
    exp = expect_bus(b, ad, m_last, m_tgl);
    vectors++;
    if (bus_data_o !== exp) begin
      errors++;
      $display("FAIL %s: bus_data_o=%h expected=%h", req, bus_data_o, exp);
    end
    @(posedge clk);
    #0.1;
    if (ld) m_last = wd;
    if (!b) m_tgl = 1'b0;
    else if (rd && !m_rdp) m_tgl = ~m_tgl;
    m_rdp = rd;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle pass-through
    step(0, 0, 0, 8'h00, 8'hA5, "R1 reset");
    step(0, 1, 0, 8'h00, 8'h3C, "R1 idle read");
    // R2: page load, last byte reported; R3 with MSB 0
    step(0, 0, 1, 8'h81, 8'h00, "R2 load1");
    step(0, 0, 1, 8'h92, 8'h00, "R2 load2");
    step(0, 0, 1, 8'h17, 8'h00, "R2 load3");
    // R5: toggle 0 at start; R3 complement => bit7=1; R6 low bits zero
    step(1, 0, 0, 8'h00, 8'hFF, "R5 start");
    step(1, 1, 0, 8'h00, 8'hFF, "R4 read1 edge");
    step(1, 1, 0, 8'h00, 8'hFF, "R4 held read");
    step(1, 1, 0, 8'h00, 8'hFF, "R4 held read");
    step(1, 0, 0, 8'h00, 8'hFF, "R4 gap");
    step(1, 1, 0, 8'h00, 8'hFF, "R4 read2 edge");
    step(1, 0, 0, 8'h00, 8'hFF, "R6 reserved");
    // R7: completion, true data same cycle
    step(0, 1, 0, 8'h00, 8'h17, "R7 done");
    step(0, 0, 0, 8'h00, 8'h42, "R7 idle");
    // R3 with MSB 1, R5 restart at 0
    step(0, 0, 1, 8'hC0, 8'h00, "R2 load msb1");
    step(1, 1, 0, 8'h00, 8'h11, "R5 restart with read");
    step(1, 0, 0, 8'h00, 8'h11, "R3 msb1 complement");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic b, r, l;
      b = ($urandom % 4) != 0;
      r = ($urandom % 2) != 0;
      l = ($urandom % 6) == 0;
      step(b, r, l, W'($urandom), W'($urandom), "R1-R7 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule